// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches one asynchronous input pin and, when a chosen kind of event appears on it, copies the present value of one of two free-running 16-bit timers into a capture register. The register is read as separate high and low bytes that always come from the same capture. Each capture also sets a sticky interrupt flag that software clears with a one-cycle pulse. The interrupt output is the flag gated by a separate enable, so a spurious flag raised while the mode is being changed need not reach the processor.

A 4-bit mode input selects the event: any falling edge, any rising edge, every fourth rising edge or every sixteenth rising edge. All other mode codes turn capture off. The event prescaler keeps its count while the unit stays in a capture mode, even across a change of ratio. It is cleared only when the mode leaves capture, or by reset. Software that wants a clean start for a new ratio passes through the off code first.

Top module: `cap_unit`

## Requirements
- R1: Mode codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 are capture modes. Any other code, 4'b0000 included, makes pin activity capture nothing: the flag stays clear and the capture register keeps its value.
- R2: In mode 4'b0100, every falling edge of the pin causes a capture and a rising edge causes none.
- R3: In mode 4'b0101, every rising edge of the pin causes a capture and a falling edge causes none.
- R4: In mode 4'b0110, a capture happens on every 4th rising edge. In mode 4'b0111, a capture happens on every 16th rising edge. Counting starts from a cleared prescaler.
- R5: A pin change is first registered at some clock edge. The capture takes place at the third clock edge after that one, and it stores the timer value present at that edge. The flag rises at the same edge.
- R6: With `tmr_sel_i` = 0 the capture takes `tmr_a_i`. With `tmr_sel_i` = 1 it takes `tmr_b_i`.
- R7: `cap_hi_o` is bits 15:8 and `cap_lo_o` is bits 7:0 of one captured word. A later capture overwrites an unread one with no other indication.
- R8: The flag stays set until a `flag_clr_i` pulse clears it. If a clear and a capture fall in the same cycle, the flag ends set.
- R9: Reset, or any cycle with a non-capture mode, clears the prescaler count.
- R10: A direct change from one prescale ratio to another keeps the count. The next capture therefore comes once the count reaches the new limit, which can be early.
- R11: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R12: After reset the capture register reads 0 and the flag and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Capture event and prescale select |
| tmr_sel_i | input | 1 | Timer source select (0 = A, 1 = B) |
| tmr_a_i | input | 16 | Free-running timer A value |
| tmr_b_i | input | 16 | Free-running timer B value |
| pin_i | input | 1 | Asynchronous event pin |
| flag_clr_i | input | 1 | One-cycle flag clear |
| irq_en_i | input | 1 | Interrupt enable |
| cap_hi_o | output | 8 | Captured value, high byte |
| cap_lo_o | output | 8 | Captured value, low byte |
| flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The capture path is swept over both timer selects and eight timer words whose two bytes differ. This shows whether the right source is taken and whether the bytes pair up. The pin is driven with separate rising and falling halves in every edge mode, to separate falling from rising detection. For the prescale ratios, the bench counts the pulses before the first flag, starting from a cleared count, from a count carried across a ratio change, and from a count cleared by a stop in the off code. The timer value is changed exactly one cycle before the expected capture edge. The clear pulse is also placed on that edge, which pins down both the latency and the set-over-clear priority.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam logic [3:0] CM_OFF   = 4'b0000;
   localparam logic [3:0] CM_FALL  = 4'b0100;
   localparam logic [3:0] CM_RISE  = 4'b0101;
   localparam logic [3:0] CM_DIV4  = 4'b0110;
   localparam logic [3:0] CM_DIV16 = 4'b0111;

   function automatic logic is_capture(input logic [3:0] m);
      return m[3:2] == 2'b01;
   endfunction

   function automatic logic is_divided(input logic [3:0] m);
      return (m == CM_DIV4) || (m == CM_DIV16);
   endfunction

   // last count value before the prescaler fires
   function automatic logic [3:0] div_limit(input logic [3:0] m);
      return (m == CM_DIV16) ? 4'd15 : 4'd3;
   endfunction
endpackage

// File: rtl/cap_edge.sv
module cap_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cap_edge: STAGES must be at least 2");
   end

   logic sh [STAGES];
   logic prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= pin_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sh[LAST];

   assign rise_o = sh[LAST] & ~prev_q;
   assign fall_o = ~sh[LAST] & prev_q;
endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
   import cap_pkg::*;
#(
   parameter int PS_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       hit_o
);
   if (PS_W < 4) begin : g_bad_width
      $error("cap_prescale: PS_W must hold a count of 15");
   end

   logic [PS_W-1:0] cnt_q;
   logic            cap_on, divided, edge_seen, at_limit;

   assign cap_on    = is_capture(mode_i);
   assign divided   = is_divided(mode_i);
   assign edge_seen = (mode_i == CM_FALL) ? fall_i : rise_i;
   assign at_limit  = cnt_q >= PS_W'(div_limit(mode_i));
   assign hit_o     = cap_on && edge_seen && (!divided || at_limit);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         cnt_q <= '0;
      else if (!cap_on)
         cnt_q <= '0;
      else if (divided && edge_seen)
         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;

   // R9
   psc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_capture(mode_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
   parameter int TW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic            tmr_sel_i,
   input  logic [TW-1:0]   tmr_a_i,
   input  logic [TW-1:0]   tmr_b_i,
   input  logic            flag_clr_i,
   output logic [TW/2-1:0] hi_o,
   output logic [TW/2-1:0] lo_o,
   output logic            flag_o
);
   localparam int HALF = TW / 2;

   if (TW % 2 != 0) begin : g_bad_tw
      $error("cap_latch: TW must be even");
   end

   logic          hit_q;
   logic [TW-1:0] cap_q;
   logic [TW-1:0] src;

   assign src = tmr_sel_i ? tmr_b_i : tmr_a_i;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         hit_q  <= 1'b0;
         cap_q  <= '0;
         flag_o <= 1'b0;
      end else begin
         hit_q <= hit_i;
         if (hit_q) cap_q <= src;
         if (hit_q)           flag_o <= 1'b1;
         else if (flag_clr_i) flag_o <= 1'b0;
      end

   assign hi_o = cap_q[TW-1:HALF];
   assign lo_o = cap_q[HALF-1:0];

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr_i) |=> flag_o);
   // R5
   cap_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> ##1 flag_o);
   // R7
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_q |=> $stable({hi_o, lo_o}));
endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int PS_W        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    mode_i,
   input  logic          tmr_sel_i,
   input  logic [TW-1:0] tmr_a_i,
   input  logic [TW-1:0] tmr_b_i,
   input  logic          pin_i,
   input  logic          flag_clr_i,
   input  logic          irq_en_i,
   output logic [7:0]    cap_hi_o,
   output logic [7:0]    cap_lo_o,
   output logic          flag_o,
   output logic          irq_o
);
   if (TW != 16) begin : g_bad_top
      $error("cap_unit: byte ports need TW of 16");
   end

   logic rise, fall, hit;

   cap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
      .rise_o(rise), .fall_o(fall)
   );

   cap_prescale #(.PS_W(PS_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rise_i(rise), .fall_i(fall), .hit_o(hit)
   );

   cap_latch #(.TW(TW)) u_latch (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .tmr_sel_i(tmr_sel_i),
      .tmr_a_i(tmr_a_i), .tmr_b_i(tmr_b_i), .flag_clr_i(flag_clr_i),
      .hi_o(cap_hi_o), .lo_o(cap_lo_o), .flag_o(flag_o)
   );

   assign irq_o = flag_o & irq_en_i;

   // R11
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && $rose(flag_o)) |-> irq_o);
endmodule

// File: tb/tb_cap_unit.sv
module tb_cap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  mode = 4'b0000;
   logic        tsel = 1'b0;
   logic [15:0] ta = '0, tb = '0;
   logic        pin = 1'b0, clr = 1'b0, ien = 1'b0;
   logic [7:0]  hi, lo;
   logic        flag, irq;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cap_unit dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .tmr_sel_i(tsel),
      .tmr_a_i(ta), .tmr_b_i(tb), .pin_i(pin), .flag_clr_i(clr),
      .irq_en_i(ien), .cap_hi_o(hi), .cap_lo_o(lo), .flag_o(flag), .irq_o(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse();
      pin = 1'b1; tick(4);
      pin = 1'b0; tick(4);
   endtask

   task automatic clear_flag();
      clr = 1'b1; tick(1); clr = 1'b0;
   endtask

   task automatic set_mode(input logic [3:0] m);
      mode = 4'b0000; tick(1);
      mode = m; tick(1);
      clear_flag();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp;
      tick(3); rst_n = 1'b1; tick(1);
      // R12 reset state
      chk({hi, lo} == 16'h0, "R12 cap", {hi, lo}, 0);
      chk(!flag && !irq, "R12 flag", flag, 0);

      // R1 off and unused codes
      ta = 16'hBEEF;
      mode = 4'b0000; pulse();
      chk(!flag, "R1 off flag", flag, 0);
      mode = 4'b1011; pulse();
      mode = 4'b0001; pulse();
      chk(!flag, "R1 unused flag", flag, 0);
      chk({hi, lo} == 16'h0, "R1 cap kept", {hi, lo}, 0);

      // R6 R7 sweep over sources and words
      set_mode(4'b0101);
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < 8; i++) begin
            tsel = s[0];
            ta = 16'h1357 + 16'(i) * 16'h2469;
            tb = ~ta ^ (16'(i) * 16'h0101);
            exp = s[0] ? tb : ta;
            clear_flag();
            pulse();
            chk({hi, lo} == exp, "R6 R7 source word", {hi, lo}, exp);
            chk(flag, "R6 flag", flag, 1);
         end
      end
      tsel = 1'b0;

      // R3 rising only
      clear_flag(); ta = 16'h0A0B;
      pin = 1'b1; tick(4);
      chk(flag && {hi, lo} == 16'h0A0B, "R3 rise capture", {hi, lo}, 16'h0A0B);
      clear_flag(); ta = 16'h5555;
      pin = 1'b0; tick(4);
      chk(!flag, "R3 fall ignored", flag, 0);

      // R2 falling only
      set_mode(4'b0100); ta = 16'hC0DE;
      pin = 1'b1; tick(4);
      chk(!flag, "R2 rise ignored", flag, 0);
      pin = 1'b0; tick(4);
      chk(flag && {hi, lo} == 16'hC0DE, "R2 fall capture", {hi, lo}, 16'hC0DE);

      // R5 latency and timer value at capture edge
      set_mode(4'b0101); ta = 16'h1111;
      pin = 1'b1; tick(3);
      chk(!flag, "R5 not yet", flag, 0);
      ta = 16'h2222; tick(1);
      chk(flag, "R5 flag edge", flag, 1);
      chk({hi, lo} == 16'h2222, "R5 value", {hi, lo}, 16'h2222);
      pin = 1'b0; tick(4);

      // R7 overwrite
      clear_flag(); ta = 16'h3344; pulse();
      ta = 16'h5566; pulse();
      chk({hi, lo} == 16'h5566, "R7 overwrite", {hi, lo}, 16'h5566);

      // R8 sticky, clear, collision
      tick(5);
      chk(flag, "R8 sticky", flag, 1);
      clear_flag(); tick(1);
      chk(!flag, "R8 cleared", flag, 0);
      ta = 16'h7788;
      pin = 1'b1; tick(3);
      clr = 1'b1; tick(1); clr = 1'b0;
      chk(flag, "R8 set wins", flag, 1);
      pin = 1'b0; tick(4);

      // R11 gating
      ien = 1'b0; tick(1);
      chk(!irq, "R11 disabled", irq, 0);
      ien = 1'b1; tick(1);
      chk(irq, "R11 enabled", irq, 1);
      clear_flag(); tick(1);
      chk(!irq, "R11 no flag", irq, 0);
      ien = 1'b0;

      // R4 divide by 4 and by 16
      set_mode(4'b0110);
      for (int n = 1; n <= 4; n++) begin
         ta = 16'(n) * 16'h0111;
         pulse();
         chk(flag == (n == 4), "R4 div4 count", flag, n == 4);
      end
      chk({hi, lo} == 16'h0444, "R4 div4 value", {hi, lo}, 16'h0444);
      set_mode(4'b0111);
      for (int n = 1; n <= 16; n++) begin
         ta = 16'(n) + 16'h9000;
         pulse();
         chk(flag == (n == 16), "R4 div16 count", flag, n == 16);
      end
      chk({hi, lo} == 16'h9010, "R4 div16 value", {hi, lo}, 16'h9010);

      // R9 off clears count
      set_mode(4'b0110);
      pulse(); pulse();
      mode = 4'b0000; tick(1); mode = 4'b0110; tick(1);
      pulse(); pulse(); pulse();
      chk(!flag, "R9 restart from zero", flag, 0);
      pulse();
      chk(flag, "R9 fourth fires", flag, 1);

      // R10 direct ratio change keeps count
      set_mode(4'b0111);
      pulse(); pulse();
      mode = 4'b0110;
      pulse();
      chk(!flag, "R10 count 2 one more", flag, 0);
      pulse();
      chk(flag, "R10 early fire", flag, 1);
      set_mode(4'b0111);
      for (int n = 0; n < 10; n++) pulse();
      chk(!flag, "R10 div16 partial", flag, 0);
      mode = 4'b0110;
      pulse();
      chk(flag, "R10 high count fires", flag, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule